// File: doc/BRIEF.md
# DMA Channel Suspend and Disable Control

This block holds the run control for a set of DMA channels. Each channel has its own byte FIFO that packs source beats into destination words. It has its own source read port and destination write port, and each port has a simple request/ready handshake with a two-bit response. Software drives a per-channel enable request, a per-channel suspend bit and one global enable level. It reads back a per-channel running status and a packing-aware "nothing left to send" flag.

The block treats a disable as a request. If there is no retried access, a channel stops at the first clock edge that sees the request. Any access in flight at that point is dropped without a response. When an access has been answered with RETRY or SPLIT, the channel keeps reissuing that same address until it receives OKAY, and only then does it stop. Every stop empties the FIFO. Suspension blocks new source reads. It still lets complete destination words drain, and clearing it resumes the transfer where it left off.

Top module: `dma_susp_ctrl`

## Requirements
- R1: After reset every channel reports `ch_en_o`=0 and `fifo_empty_o`=1, and issues no source or destination request.
- R2: A channel starts when its enable request and `glb_en_i` are both 1. `ch_en_o` reads 1 after the next clock edge, and both addresses restart at 0.
- R3: Width codes 0, 1 and 2 mean 1, 2 and 4 bytes, and a code of 3 is never used. Source beats are packed little-endian in address order. Each destination word with OKAY carries the bytes at destination addresses `dst_addr_o`..`dst_addr_o`+width-1, and the unused upper bytes are 0. Each address advances by its own width on every OKAY.
- R4: `fifo_empty_o` is 1 exactly when the FIFO holds fewer bytes than one destination word. This stays true even when some bytes remain.
- R5: While `susp_i` is 1 a channel issues no new source read. It keeps writing complete destination words until none can be formed.
- R6: Clearing `susp_i` resumes source reads from the next unread address, and the transfer continues.
- R7: When a disable is requested and no retried access is pending, requests drop at once and `ch_en_o` reads 0 after the next clock edge.
- R8: A RETRY (2) or SPLIT (3) response leaves the access pending. The same address is requested again every cycle until OKAY (0) arrives, even when the channel is suspended or a disable is requested. Meanwhile `ch_en_o` stays 1.
- R9: With a disable requested, `ch_en_o` reads 0 no later than two clock edges after the edge that sampled OKAY on the pending access. No new access starts in between.
- R10: `glb_en_i`=0 requests a disable of every channel. Each channel completes the disable on its own, so a channel with a pending retry stays enabled while the others stop.
- R11: Stopping a channel discards its FIFO contents. After it is enabled again, `fifo_empty_o` is 1 and no old data reaches the destination.
- R12: Leftover bytes of a suspended channel that cannot form a destination word are discarded when the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable level |
| ch_en_req_i | input | NUM_CH | Per-channel enable request |
| susp_i | input | NUM_CH | Per-channel suspend |
| src_w_i | input | 2*NUM_CH | Source width code per channel |
| dst_w_i | input | 2*NUM_CH | Destination width code per channel |
| src_req_o | output | NUM_CH | Source read request |
| src_addr_o | output | AW*NUM_CH | Source byte offset |
| src_rdy_i | input | NUM_CH | Source response valid |
| src_resp_i | input | 2*NUM_CH | Source response code |
| src_rdata_i | input | 32*NUM_CH | Source read data |
| dst_req_o | output | NUM_CH | Destination write request |
| dst_addr_o | output | AW*NUM_CH | Destination byte offset |
| dst_wdata_o | output | 32*NUM_CH | Destination write data |
| dst_rdy_i | input | NUM_CH | Destination response valid |
| dst_resp_i | input | 2*NUM_CH | Destination response code |
| ch_en_o | output | NUM_CH | Channel running status |
| fifo_empty_o | output | NUM_CH | No complete destination word buffered |

## Verification
The assertions assume that width codes are never 3. They also assume that no response with code 1 arrives on a requested access, and that width codes stay fixed while a channel runs. The bench changes widths only between scenarios while every channel is stopped, and it drives only OKAY, RETRY and SPLIT. Its source model returns bytes that depend only on the address. This lets every destination word be predicted from the destination address alone, so any stale or misordered byte shows up as a data mismatch.

// File: rtl/dma_sd_pkg.sv
package dma_sd_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY  = 2'd0,
    RSP_RETRY = 2'd2,
    RSP_SPLIT = 2'd3
  } rsp_e;

  localparam int unsigned BUS_BYTES = 4;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] byte_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/dma_sd_fifo.sv
module dma_sd_fifo
  import dma_sd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [2:0]    push_n_i,
  input  logic [31:0]   push_data_i,
  input  logic          pop_i,
  input  logic [2:0]    pop_n_i,
  output logic [31:0]   head_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned BW = 8 * DEPTH;

  logic [BW-1:0] data_q, data_d;
  logic [CW-1:0] count_q, count_d;
  logic [CW-1:0] base;

  always_comb begin
    data_d  = data_q;
    base    = count_q;
    if (pop_i) begin
      data_d = data_q >> (8 * pop_n_i);
      base   = count_q - CW'(pop_n_i);
    end
    count_d = base;
    if (push_i) begin
      data_d  = data_d | (BW'(push_data_i & byte_mask(push_n_i)) << (8 * base));
      count_d = base + CW'(push_n_i);
    end
    if (flush_i) begin
      data_d  = '0;
      count_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      count_q <= '0;
    end else begin
      data_q  <= data_d;
      count_q <= count_d;
    end
  end

  assign head_o  = data_q[31:0];
  assign count_o = count_q;

  a_r5_room_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ({1'b0, count_q} + (CW+1)'(push_n_i)) <=
               ((CW+1)'(DEPTH) + (pop_i ? (CW+1)'(pop_n_i) : '0)));
  a_r4_pop_whole_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q >= CW'(pop_n_i));
endmodule

// File: rtl/dma_sd_chan.sv
module dma_sd_chan
  import dma_sd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          susp_i,
  input  logic [1:0]    src_w_i,
  input  logic [1:0]    dst_w_i,
  output logic          src_req_o,
  output logic [AW-1:0] src_addr_o,
  input  logic          src_rdy_i,
  input  logic [1:0]    src_resp_i,
  input  logic [31:0]   src_rdata_i,
  output logic          dst_req_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [31:0]   dst_wdata_o,
  input  logic          dst_rdy_i,
  input  logic [1:0]    dst_resp_i,
  output logic          ch_en_o,
  output logic          fifo_empty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e           st_q;
  logic          src_pend_q, dst_pend_q;
  logic [AW-1:0] src_addr_q, dst_addr_q;
  logic [2:0]    sb, db;
  logic [CW-1:0] cnt;
  logic [31:0]   head;
  logic          run, dis_req, room, leave, start;
  logic          src_ok, src_stall, dst_ok, dst_stall;

  assign sb      = width_bytes(src_w_i);
  assign db      = width_bytes(dst_w_i);
  assign run     = (st_q == ST_RUN);
  assign dis_req = !en_i;
  assign room    = ({1'b0, cnt} + (CW+1)'(sb)) <= (CW+1)'(DEPTH);
  assign start   = !run && en_i;
  assign leave   = run && dis_req && !src_pend_q && !dst_pend_q;

  // a retried access is always reissued, whatever suspend or disable say
  assign src_req_o = run && (src_pend_q || (!dis_req && !susp_i && room));
  assign dst_req_o = run && (dst_pend_q || (!dis_req && (cnt >= CW'(db))));

  assign src_ok    = src_req_o && src_rdy_i && (src_resp_i == 2'(RSP_OKAY));
  assign src_stall = src_req_o && src_rdy_i &&
                     (src_resp_i == 2'(RSP_RETRY) || src_resp_i == 2'(RSP_SPLIT));
  assign dst_ok    = dst_req_o && dst_rdy_i && (dst_resp_i == 2'(RSP_OKAY));
  assign dst_stall = dst_req_o && dst_rdy_i &&
                     (dst_resp_i == 2'(RSP_RETRY) || dst_resp_i == 2'(RSP_SPLIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      src_pend_q <= 1'b0;
      dst_pend_q <= 1'b0;
      src_addr_q <= '0;
      dst_addr_q <= '0;
    end else begin
      if (start) begin
        st_q       <= ST_RUN;
        src_addr_q <= '0;
        dst_addr_q <= '0;
      end else if (leave) begin
        st_q <= ST_IDLE;
      end else begin
        if (src_ok) src_addr_q <= src_addr_q + AW'(sb);
        if (dst_ok) dst_addr_q <= dst_addr_q + AW'(db);
      end
      if (!run)           src_pend_q <= 1'b0;
      else if (src_stall) src_pend_q <= 1'b1;
      else if (src_ok)    src_pend_q <= 1'b0;
      if (!run)           dst_pend_q <= 1'b0;
      else if (dst_stall) dst_pend_q <= 1'b1;
      else if (dst_ok)    dst_pend_q <= 1'b0;
    end
  end

  dma_sd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (leave),
    .push_i      (src_ok),
    .push_n_i    (sb),
    .push_data_i (src_rdata_i),
    .pop_i       (dst_ok),
    .pop_n_i     (db),
    .head_o      (head),
    .count_o     (cnt)
  );

  assign src_addr_o   = src_addr_q;
  assign dst_addr_o   = dst_addr_q;
  assign dst_wdata_o  = head & byte_mask(db);
  assign ch_en_o      = run;
  assign fifo_empty_o = cnt < CW'(db);

  a_r3_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_w_i != 2'd3 && dst_w_i != 2'd3);
  a_r8_resp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_req_o && src_rdy_i) |-> src_resp_i != 2'd1);
  a_r8_src_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_stall |=> src_req_o && $stable(src_addr_o));
  a_r8_dst_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_stall |=> dst_req_o && $stable(dst_addr_o));
  a_r8_hold_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (src_pend_q || dst_pend_q)) |=> ch_en_o);
  a_r5_no_src_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && !src_pend_q) |-> !src_req_o);
  a_r11_flush_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ch_en_o) |-> cnt == '0);
  a_r4_no_write_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty_o && !dst_pend_q) |-> !dst_req_o);
endmodule

// File: rtl/dma_susp_ctrl.sv
module dma_susp_ctrl
  import dma_sd_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned FIFO_BYTES = 8,
  parameter int unsigned AW         = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   glb_en_i,
  input  logic [NUM_CH-1:0]      ch_en_req_i,
  input  logic [NUM_CH-1:0]      susp_i,
  input  logic [2*NUM_CH-1:0]    src_w_i,
  input  logic [2*NUM_CH-1:0]    dst_w_i,
  output logic [NUM_CH-1:0]      src_req_o,
  output logic [AW*NUM_CH-1:0]   src_addr_o,
  input  logic [NUM_CH-1:0]      src_rdy_i,
  input  logic [2*NUM_CH-1:0]    src_resp_i,
  input  logic [32*NUM_CH-1:0]   src_rdata_i,
  output logic [NUM_CH-1:0]      dst_req_o,
  output logic [AW*NUM_CH-1:0]   dst_addr_o,
  output logic [32*NUM_CH-1:0]   dst_wdata_o,
  input  logic [NUM_CH-1:0]      dst_rdy_i,
  input  logic [2*NUM_CH-1:0]    dst_resp_i,
  output logic [NUM_CH-1:0]      ch_en_o,
  output logic [NUM_CH-1:0]      fifo_empty_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_sd_chan #(.DEPTH(FIFO_BYTES), .AW(AW)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (ch_en_req_i[c] && glb_en_i),
      .susp_i       (susp_i[c]),
      .src_w_i      (src_w_i[2*c +: 2]),
      .dst_w_i      (dst_w_i[2*c +: 2]),
      .src_req_o    (src_req_o[c]),
      .src_addr_o   (src_addr_o[AW*c +: AW]),
      .src_rdy_i    (src_rdy_i[c]),
      .src_resp_i   (src_resp_i[2*c +: 2]),
      .src_rdata_i  (src_rdata_i[32*c +: 32]),
      .dst_req_o    (dst_req_o[c]),
      .dst_addr_o   (dst_addr_o[AW*c +: AW]),
      .dst_wdata_o  (dst_wdata_o[32*c +: 32]),
      .dst_rdy_i    (dst_rdy_i[c]),
      .dst_resp_i   (dst_resp_i[2*c +: 2]),
      .ch_en_o      (ch_en_o[c]),
      .fifo_empty_o (fifo_empty_o[c])
    );
  end

  initial begin
    a_cfg_depth: assert (FIFO_BYTES >= BUS_BYTES);
  end
endmodule

// File: tb/sim_dma_susp_ctrl.sv
module sim_dma_susp_ctrl;
  localparam int NCH = 2;
  localparam int AW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0;
  logic [NCH-1:0]    en_req = '0, susp = '0, src_rdy = '0, dst_rdy = '0;
  logic [2*NCH-1:0]  src_w = '0, dst_w = '0, src_resp = '0, dst_resp = '0;
  logic [32*NCH-1:0] src_rdata;
  logic [NCH-1:0]    src_req, dst_req, ch_en, fifo_empty;
  logic [AW*NCH-1:0] src_addr, dst_addr;
  logic [32*NCH-1:0] dst_wdata;

  int n_chk = 0, n_fail = 0, n_beats = 0;

  always #2 clk = ~clk;

  dma_susp_ctrl #(.NUM_CH(NCH), .FIFO_BYTES(8), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .ch_en_req_i(en_req),
    .susp_i(susp), .src_w_i(src_w), .dst_w_i(dst_w),
    .src_req_o(src_req), .src_addr_o(src_addr), .src_rdy_i(src_rdy),
    .src_resp_i(src_resp), .src_rdata_i(src_rdata),
    .dst_req_o(dst_req), .dst_addr_o(dst_addr), .dst_wdata_o(dst_wdata),
    .dst_rdy_i(dst_rdy), .dst_resp_i(dst_resp),
    .ch_en_o(ch_en), .fifo_empty_o(fifo_empty)
  );

  function automatic logic [7:0] mem_byte(int a);
    return 8'(a * 7 + 3);
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++)
        src_rdata[32*c + 8*k +: 8] = mem_byte(int'(src_addr[AW*c +: AW]) + k);
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 data monitor: every accepted destination word is predicted from its address
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst_n && dst_req[c] && dst_rdy[c] && dst_resp[2*c +: 2] == 2'd0) begin
        logic [31:0] w;
        int nb;
        w  = '0;
        nb = 1 << dst_w[2*c +: 2];
        for (int k = 0; k < 4; k++)
          if (k < nb) w[8*k +: 8] = mem_byte(int'(dst_addr[AW*c +: AW]) + k);
        n_beats++;
        chk("R3 dst word", int'(dst_wdata[32*c +: 32]), int'(w));
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_all();
    en_req = '0; susp = '0; src_rdy = '0; dst_rdy = '0;
    src_resp = '0; dst_resp = '0; glb_en = 1'b1;
    cyc(2);
  endtask

  function automatic int sa(int c); return int'(src_addr[AW*c +: AW]); endfunction
  function automatic int da(int c); return int'(dst_addr[AW*c +: AW]); endfunction

  task automatic t_reset();
    chk("R1 ch_en", int'(ch_en), 0);
    chk("R1 fifo_empty", int'(fifo_empty), 3);
    chk("R1 src_req", int'(src_req), 0);
    chk("R1 dst_req", int'(dst_req), 0);
  endtask

  task automatic t_pack(int sw, int dw);
    int b0;
    idle_all();
    src_w[1:0] = 2'(sw); dst_w[1:0] = 2'(dw);
    src_rdy[0] = 1'b1; dst_rdy[0] = 1'b1;
    en_req[0] = 1'b1;
    cyc(1);
    chk("R2 started", int'(ch_en[0]), 1);
    chk("R2 src addr", sa(0), 0);
    chk("R2 dst addr", da(0), 0);
    b0 = n_beats;
    cyc(24);
    chk("R3 words written", int'(n_beats > b0 + 2), 1);
    chk("R3 src step", sa(0) % (1 << sw), 0);
    en_req[0] = 1'b0;
    #1;
    chk("R7 requests dropped", int'(src_req[0] | dst_req[0]), 0);
    cyc(1);
    chk("R7 stopped", int'(ch_en[0]), 0);
  endtask

  task automatic fill6();
    src_rdy[0] = 1'b0; dst_rdy[0] = 1'b1;
    en_req[0] = 1'b1;
    cyc(1);
    src_rdy[0] = 1'b1;
    cyc(6);
    susp[0] = 1'b1;
    cyc(3);
  endtask

  task automatic t_suspend();
    idle_all();
    src_w[1:0] = 2'd0; dst_w[1:0] = 2'd2;
    fill6();
    chk("R5 no src read", int'(src_req[0]), 0);
    chk("R5 src addr held", sa(0), 6);
    chk("R5 drained word", da(0), 4);
    chk("R4 partial is empty", int'(fifo_empty[0]), 1);
    chk("R5 still enabled", int'(ch_en[0]), 1);
    susp[0] = 1'b0;
    cyc(12);
    chk("R6 src resumed", int'(sa(0) > 6), 1);
    chk("R6 dst resumed", int'(da(0) > 4), 1);
    en_req[0] = 1'b0;
    cyc(1);
    chk("R7 stopped", int'(ch_en[0]), 0);
    susp[0] = 1'b0;
    fill6();
    en_req[0] = 1'b0;
    cyc(1);
    chk("R12 stopped in susp", int'(ch_en[0]), 0);
    susp[0] = 1'b0; src_rdy[0] = 1'b0; en_req[0] = 1'b1;
    cyc(1);
    src_rdy[0] = 1'b1;
    cyc(2);
    src_rdy[0] = 1'b0;
    cyc(2);
    chk("R12 leftover gone", int'(fifo_empty[0]), 1);
    chk("R12 no stale word", da(0), 0);
    chk("R12 no write", int'(dst_req[0]), 0);
  endtask

  task automatic t_flush();
    idle_all();
    src_w[1:0] = 2'd2; dst_w[1:0] = 2'd2;
    en_req[0] = 1'b1;
    cyc(1);
    src_rdy[0] = 1'b1;
    cyc(4);
    chk("R4 full words held", int'(fifo_empty[0]), 0);
    chk("R4 fifo full", int'(src_req[0]), 0);
    en_req[0] = 1'b0;
    cyc(1);
    chk("R7 stopped", int'(ch_en[0]), 0);
    src_rdy[0] = 1'b0; en_req[0] = 1'b1;
    cyc(1);
    chk("R11 restarted", int'(ch_en[0]), 1);
    chk("R11 flushed", int'(fifo_empty[0]), 1);
  endtask

  task automatic t_retry();
    idle_all();
    src_w[1:0] = 2'd2; dst_w[1:0] = 2'd2;
    src_rdy[0] = 1'b1; src_resp[1:0] = 2'd2;
    en_req[0] = 1'b1;
    cyc(4);
    chk("R8 reissue", int'(src_req[0]), 1);
    chk("R8 same addr", sa(0), 0);
    susp[0] = 1'b1; en_req[0] = 1'b0;
    cyc(3);
    chk("R8 held enabled", int'(ch_en[0]), 1);
    chk("R8 still reissuing", int'(src_req[0]), 1);
    chk("R8 addr kept", sa(0), 0);
    src_resp[1:0] = 2'd0;
    cyc(1);
    chk("R9 no new access", int'(src_req[0] | dst_req[0]), 0);
    cyc(1);
    chk("R9 disabled", int'(ch_en[0]), 0);
  endtask

  task automatic t_global();
    idle_all();
    src_w = 4'b1000; dst_w = 4'b1000;
    src_rdy = 2'b11; dst_rdy = 2'b11;
    dst_resp[3:2] = 2'd3;
    en_req = 2'b11;
    cyc(6);
    chk("R8 dst split pending", int'(dst_req[1]), 1);
    chk("R8 dst addr", da(1), 0);
    glb_en = 1'b0;
    cyc(1);
    chk("R10 ch0 stopped", int'(ch_en[0]), 0);
    chk("R10 ch1 held", int'(ch_en[1]), 1);
    cyc(3);
    chk("R10 ch1 still held", int'(ch_en[1]), 1);
    chk("R8 dst addr kept", da(1), 0);
    dst_resp[3:2] = 2'd0;
    cyc(2);
    chk("R10 ch1 stopped", int'(ch_en[1]), 0);
    src_rdy = '0;
    glb_en = 1'b1;
    cyc(1);
    chk("R2 both restart", int'(ch_en), 3);
    chk("R11 ch1 flushed", int'(fifo_empty[1]), 1);
    en_req = '0;
    cyc(2);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_pack(0, 2);
    t_pack(1, 2);
    t_pack(2, 0);
    t_pack(2, 1);
    t_pack(0, 0);
    t_suspend();
    t_flush();
    t_retry();
    t_global();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule